// File: doc/BRIEF.md
# Asynchronous SRAM Lane Controller

This block connects a clocked request bus to an external asynchronous static RAM that stores 65536 words of 18 bits. The word is split into two 9-bit lanes, and each lane has its own active-low select. A requester presents one read or write at a time with a valid/ready handshake. Each request carries a 16-bit address, 18-bit write data and a 2-bit lane mask. The controller converts each request into the chip-enable, write-strobe, output-enable and lane-select pattern the RAM needs. It holds every phase for enough clock cycles to meet the RAM's minimum strobe width, access time and bus release time. Read data returns on a one-cycle response pulse.

Three cycle counts set the timing. Each comes from a time in picoseconds divided by the clock period, rounded up, with a floor of one. The read count covers both the access time and the cycle time. The write count covers both the strobe width and the cycle time. The turnaround count covers the time the RAM may take to release the data bus after its outputs are switched off. The controller drives the shared data bus only while the write strobe is low. A write that follows a read first waits through a turnaround phase, so the RAM has released the bus before the controller drives it.

The controller has four states. In ST_IDLE it accepts a request. A read goes to ST_READ. A write goes to ST_WRITE, or to ST_TURN when the last access was a read. A request with an empty lane mask is dropped and the controller stays in ST_IDLE. ST_READ returns to ST_IDLE after the read count. ST_TURN moves to ST_WRITE after the turnaround count. ST_WRITE returns to ST_IDLE after the write count.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, the RAM strobes are inactive: mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n are 1 and mem_dq_oe is 0. At the same time req_ready is 1 and rsp_valid is 0.
- R2: A read is accepted at a clock edge where req_valid and req_ready are both 1 and req_write is 0. For the next RD_CYC cycles the controller drives mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0. mem_addr equals the request address. mem_lb_n is the inverse of lane bit 0 and mem_ub_n is the inverse of lane bit 1.
- R3: mem_dq_i is sampled at the edge that ends the last read cycle. In the following cycle rsp_valid is 1, and it is 1 for exactly that one cycle. In rsp_rdata, bits 8:0 carry the RAM's bits 8:0 when lane bit 0 was set and are 0 otherwise. Bits 17:9 carry the RAM's bits 17:9 when lane bit 1 was set and are 0 otherwise.
- R4: During an accepted write, the write phase lasts WR_CYC cycles. In each of them mem_ce_n=0, mem_we_n=0, mem_oe_n=1, mem_dq_oe=1 and mem_dq_o equals the request data, with the lane selects mapped as in R2. The next cycle returns every strobe to inactive, and a write never raises rsp_valid.
- R5: mem_dq_oe is 1 only in cycles where mem_we_n and mem_ce_n are both 0.
- R6: A write accepted after a read, with no write between them, first spends TURN_CYC cycles with mem_ce_n, mem_oe_n and mem_we_n at 1 and mem_dq_oe at 0. A write accepted after another write starts its write phase in the cycle right after acceptance.
- R7: A request whose lane mask is 00 is accepted and then dropped. No strobe goes active, no response is produced, and req_ready stays 1.
- R8: req_ready is 1 only in ST_IDLE and is 0 in every cycle of a read, turnaround or write phase.
- R9: RD_CYC is the larger of the access-time and cycle-time counts. WR_CYC is the larger of the strobe-width and cycle-time counts. TURN_CYC is the turnaround count. Each count is ceil(time_ps / CLK_PS), with a minimum of 1.
- R10: mem_oe_n and mem_we_n are never both 0. While mem_ce_n is 0, at least one lane select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 18 | Write data, bits 8:0 lower lane, bits 17:9 upper lane |
| req_lane | input | 2 | Lane mask, bit 0 lower, bit 1 upper |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 18 | Read data, with unselected lanes set to 0 |
| mem_addr | output | 16 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_lb_n | output | 1 | Lower-lane select, active low |
| mem_ub_n | output | 1 | Upper-lane select, active low |
| mem_dq_o | output | 18 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the mem_dq_o pad drivers |
| mem_dq_i | input | 18 | Data received from the RAM |

## Verification
A wrong state or a wrong phase counter shows up at the RAM pins within one cycle of the fault:

- A phase that is one cycle short or long changes where mem_ce_n rises.
- A skipped turnaround makes mem_we_n fall right after acceptance.
- A stuck state holds req_ready low until the watchdog expires.

A wrong lane mapping or a wrong capture point appears in rsp_rdata in the cycle after the read phase. The bench models the RAM, returns junk on unselected lanes, and compares each response with a reference copy of the memory.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_TURN  = 2'd2,
        ST_WRITE = 2'd3
    } ctl_state_e;

    // Whole clock cycles covering a time in picoseconds, never below one.
    function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] last_idx,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != {CW{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == last_idx);
endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] raw_data,
    output logic [LANES-1:0]        sel_n,
    output logic [LANES*LANE_W-1:0] masked_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign sel_n[g] = ~lane_en[g];
        assign masked_data[g*LANE_W +: LANE_W] =
            lane_en[g] ? raw_data[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_ctl_capture.sv
module sram_ctl_capture #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic              valid,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
        end else begin
            valid <= capture;
            if (capture) begin
                dout <= din;
            end
        end
    end
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LANE_W    = 9,
    parameter int CLK_PS    = 20000,
    parameter int T_ACC_PS  = 12000,
    parameter int T_CYC_PS  = 12000,
    parameter int T_WP_PS   = 10000,
    parameter int T_TURN_PS = 6000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [2*LANE_W-1:0]    req_wdata,
    input  logic [1:0]             req_lane,
    output logic                   rsp_valid,
    output logic [2*LANE_W-1:0]    rsp_rdata,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic                   mem_ce_n,
    output logic                   mem_we_n,
    output logic                   mem_oe_n,
    output logic                   mem_lb_n,
    output logic                   mem_ub_n,
    output logic [2*LANE_W-1:0]    mem_dq_o,
    output logic                   mem_dq_oe,
    input  logic [2*LANE_W-1:0]    mem_dq_i
);
    localparam int LANES    = 2;
    localparam int DATA_W   = LANES * LANE_W;
    localparam int CYC_MIN  = ps_to_cyc(T_CYC_PS, CLK_PS);
    localparam int RD_CYC   = max2(ps_to_cyc(T_ACC_PS, CLK_PS), CYC_MIN);
    localparam int WR_CYC   = max2(ps_to_cyc(T_WP_PS, CLK_PS), CYC_MIN);
    localparam int TURN_CYC = ps_to_cyc(T_TURN_PS, CLK_PS);
    localparam int MAX_CYC  = max2(max2(RD_CYC, WR_CYC), TURN_CYC);
    localparam int CW       = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam logic [CW-1:0] RD_LAST   = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LAST   = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] TURN_LAST = CW'(TURN_CYC - 1);

    ctl_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  lane_q;
    logic              after_rd_q;
    logic              accept;
    logic              phase_last;
    logic [CW-1:0]     phase_idx;
    logic [LANES-1:0]  sel_n;
    logic [DATA_W-1:0] rd_masked;
    logic              lanes_on;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && (req_lane != '0)) begin
                    if (!req_write) begin
                        state_d = ST_READ;
                    end else if (after_rd_q) begin
                        state_d = ST_TURN;
                    end else begin
                        state_d = ST_WRITE;
                    end
                end
            end
            ST_READ:  if (phase_last) state_d = ST_IDLE;
            ST_TURN:  if (phase_last) state_d = ST_WRITE;
            ST_WRITE: if (phase_last) state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request holding and read-to-write tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            wdata_q    <= '0;
            lane_q     <= '0;
            after_rd_q <= 1'b0;
        end else begin
            if (accept && (req_lane != '0)) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                lane_q  <= req_lane;
            end
            if (state_q == ST_READ && phase_last) begin
                after_rd_q <= 1'b1;
            end else if (state_q == ST_WRITE) begin
                after_rd_q <= 1'b0;
            end
        end
    end

    // Phase length for the current state
    always_comb begin
        phase_idx = '0;
        unique case (state_q)
            ST_IDLE:  phase_idx = '0;
            ST_READ:  phase_idx = RD_LAST;
            ST_TURN:  phase_idx = TURN_LAST;
            ST_WRITE: phase_idx = WR_LAST;
        endcase
    end

    sram_ctl_timer #(
        .CW(CW)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_d != state_q),
        .last_idx(phase_idx),
        .last    (phase_last)
    );

    sram_ctl_lanes #(
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) lanes_i (
        .lane_en    (lane_q),
        .raw_data   (mem_dq_i),
        .sel_n      (sel_n),
        .masked_data(rd_masked)
    );

    sram_ctl_capture #(
        .DATA_W(DATA_W)
    ) capture_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture((state_q == ST_READ) && phase_last),
        .din    (rd_masked),
        .valid  (rsp_valid),
        .dout   (rsp_rdata)
    );

    // Pin decode from registered state
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        lanes_on  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_TURN: begin
            end
            ST_READ: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
                lanes_on = 1'b1;
            end
            ST_WRITE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
                lanes_on  = 1'b1;
            end
        endcase
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;
    assign mem_lb_n = lanes_on ? sel_n[0] : 1'b1;
    assign mem_ub_n = lanes_on ? sel_n[1] : 1'b1;

endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
    parameter int TURN_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_valid,
    input logic mem_ce_n,
    input logic mem_we_n,
    input logic mem_oe_n,
    input logic mem_lb_n,
    input logic mem_ub_n,
    input logic mem_dq_oe
);
    localparam int QW = $clog2(TURN_CYC + 2) + 1;

    logic [QW-1:0] quiet_q;
    logic          rd_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q   <= '0;
            rd_seen_q <= 1'b0;
        end else begin
            if (!mem_oe_n) begin
                quiet_q <= '0;
            end else if (quiet_q != {QW{1'b1}}) begin
                quiet_q <= quiet_q + 1'b1;
            end
            if (!mem_oe_n) begin
                rd_seen_q <= 1'b1;
            end else if (!mem_we_n) begin
                rd_seen_q <= 1'b0;
            end
        end
    end

    // R5
    dq_drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n));

    // R10
    oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R10
    lane_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !(mem_lb_n && mem_ub_n));

    // R3
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    // R6
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we_n) && rd_seen_q) |-> (int'(quiet_q) >= TURN_CYC));
endmodule

bind sram_async_ctl sram_async_ctl_chk #(
    .TURN_CYC(TURN_CYC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_lb_n (mem_lb_n),
    .mem_ub_n (mem_ub_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_async_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctl_tb_top;
    localparam int CLK_PS    = 20000;
    localparam int T_ACC_PS  = 45000;
    localparam int T_CYC_PS  = 12000;
    localparam int T_WP_PS   = 30000;
    localparam int T_TURN_PS = 25000;

    function automatic int cyc(input int t);
        int c;
        c = (t + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    // R9: expected counts, worked out here from the picosecond times
    localparam int E_RD   = (cyc(T_ACC_PS) > cyc(T_CYC_PS)) ? cyc(T_ACC_PS) : cyc(T_CYC_PS);
    localparam int E_WR   = (cyc(T_WP_PS) > cyc(T_CYC_PS)) ? cyc(T_WP_PS) : cyc(T_CYC_PS);
    localparam int E_TURN = cyc(T_TURN_PS);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [17:0] req_wdata = '0;
    logic [1:0]  req_lane = '0;
    logic        rsp_valid;
    logic [17:0] rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [17:0] mem_dq_o;
    logic [17:0] mem_dq_i;

    int  n_run = 0;
    int  n_fail = 0;
    bit  last_rd = 1'b0;

    logic [17:0] ram [256];
    logic [17:0] ref_mem [256];

    always #10 clk = ~clk;

    sram_async_ctl #(
        .CLK_PS(CLK_PS), .T_ACC_PS(T_ACC_PS), .T_CYC_PS(T_CYC_PS),
        .T_WP_PS(T_WP_PS), .T_TURN_PS(T_TURN_PS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_lane(req_lane), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // RAM model: lanes written while enabled and strobed; junk on deselected lanes
    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_lb_n) ram[mem_addr[7:0]][8:0]  <= mem_dq_o[8:0];
            if (!mem_ub_n) ram[mem_addr[7:0]][17:9] <= mem_dq_o[17:9];
        end
    end

    always_comb begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            mem_dq_i[8:0]  = !mem_lb_n ? ram[mem_addr[7:0]][8:0]  : 9'h15A;
            mem_dq_i[17:9] = !mem_ub_n ? ram[mem_addr[7:0]][17:9] : 9'h0A5;
        end else begin
            mem_dq_i = 18'h3FFFF;
        end
    end

    function automatic logic [17:0] init_word(input int i);
        return 18'(i * 18'h0137 + 18'h2C3);
    endfunction

    function automatic logic [17:0] exp_read(input logic [17:0] w, input logic [1:0] ln);
        return {ln[1] ? w[17:9] : 9'h0, ln[0] ? w[8:0] : 9'h0};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic issue(input bit wr, input logic [15:0] a, input logic [17:0] d, input logic [1:0] ln);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lane = ln;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle_lane_check(input string tag);
        check(mem_ce_n && req_ready && !rsp_valid, tag,
              {29'b0, mem_ce_n, req_ready, rsp_valid}, 32'h6);
        @(negedge clk);
        check(mem_ce_n && req_ready && !rsp_valid, tag,
              {29'b0, mem_ce_n, req_ready, rsp_valid}, 32'h6);
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] ln);
        logic [17:0] ew;
        issue(1'b0, a, '0, ln);
        if (ln == 2'b00) begin
            idle_lane_check("R7 empty-mask read");
            return;
        end
        for (int i = 0; i < E_RD; i++) begin
            // R2 R9 R10: strobes, address and lane selects through the read phase
            check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_lb_n, mem_ub_n, req_ready, mem_addr}
                  === {1'b0, 1'b0, 1'b1, 1'b0, ~ln[0], ~ln[1], 1'b0, a}, "R2 read phase",
                  {9'b0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_lb_n, mem_ub_n, req_ready, mem_addr},
                  {9'b0, 1'b0, 1'b0, 1'b1, 1'b0, ~ln[0], ~ln[1], 1'b0, a});
            @(negedge clk);
        end
        ew = exp_read(ref_mem[a[7:0]], ln);
        check(rsp_valid && rsp_rdata === ew, "R3 read data", {13'b0, rsp_valid, rsp_rdata}, {13'b0, 1'b1, ew});
        check(mem_ce_n && mem_oe_n && req_ready, "R8 idle after read",
              {29'b0, mem_ce_n, mem_oe_n, req_ready}, 32'h7);
        @(negedge clk);
        check(!rsp_valid, "R3 single pulse", {31'b0, rsp_valid}, 32'h0);
        last_rd = 1'b1;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [17:0] d, input logic [1:0] ln);
        issue(1'b1, a, d, ln);
        if (ln == 2'b00) begin
            idle_lane_check("R7 empty-mask write");
            return;
        end
        if (last_rd) begin
            for (int i = 0; i < E_TURN; i++) begin
                check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready} === 5'b11100,
                      "R6 turnaround", {27'b0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 32'h1C);
                @(negedge clk);
            end
        end
        for (int i = 0; i < E_WR; i++) begin
            // R4 R9 R5: write strobe width, data, lanes
            check({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, mem_lb_n, mem_ub_n, req_ready} ===
                  {1'b0, 1'b0, 1'b1, 1'b1, ~ln[0], ~ln[1], 1'b0} && mem_dq_o === d && mem_addr === a,
                  "R4 write phase",
                  {7'b0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, mem_lb_n, mem_ub_n, req_ready, mem_dq_o},
                  {7'b0, 1'b0, 1'b0, 1'b1, 1'b1, ~ln[0], ~ln[1], 1'b0, d});
            @(negedge clk);
        end
        check({mem_ce_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid} === 5'b11010, "R4 write end",
              {27'b0, mem_ce_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}, 32'h1A);
        if (ln[0]) ref_mem[a[7:0]][8:0]  = d[8:0];
        if (ln[1]) ref_mem[a[7:0]][17:9] = d[17:9];
        last_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R8 watchdog expired, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i] = init_word(i);
            ref_mem[i] = init_word(i);
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready, rsp_valid}
              === 8'b11111010, "R1 in reset",
              {24'b0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready, rsp_valid}, 32'hFA);
        rst_n = 1'b1;
        @(negedge clk);
        check({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready, rsp_valid}
              === 8'b11111010, "R1 after reset",
              {24'b0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready, rsp_valid}, 32'hFA);

        // Directed corners
        do_write(16'h0000, 18'h3FFFF, 2'b11);   // R6 write after write-free start: no turnaround
        do_write(16'h0001, 18'h12345, 2'b11);
        do_read (16'h0000, 2'b11);
        do_read (16'h0001, 2'b01);               // R3 lower lane only
        do_read (16'h0001, 2'b10);               // R3 upper lane only
        do_write(16'hFFFF, 18'h2AAAA, 2'b01);    // R6 write after read: turnaround
        do_write(16'hFFFF, 18'h15555, 2'b10);    // R6 write after write: none
        do_read (16'hFFFF, 2'b11);
        do_write(16'h0042, 18'h00001, 2'b00);    // R7 dropped write
        do_read (16'h0042, 2'b00);               // R7 dropped read
        do_read (16'h0042, 2'b11);               // R7 memory untouched by dropped write

        // Constrained random mix
        for (int n = 0; n < 120; n++) begin
            logic [15:0] a;
            logic [17:0] d;
            logic [1:0]  ln;
            a  = 16'($urandom);
            d  = 18'($urandom);
            ln = 2'($urandom % 4);
            if ($urandom % 2) do_write(a, d, ln);
            else              do_read(a, ln);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule